// File: doc/BRIEF.md
# Palette Memory with Backdrop Mirroring

This block is the small colour-index memory of a tile-based video processor. It keeps 32 byte-wide entries and serves two clients at once. The host processor reaches it through a data port that decodes a 14-bit video address: any address from 0x3F00 upward selects the memory, and its low five bits pick the entry, so the 256-byte window from 0x3F00 to 0x3FFF aliases the same 32 entries eight times. The pixel pipeline has its own read port and forms the entry index from a 3-bit palette number and a 2-bit pixel colour.

Entries whose index has its two low bits at zero are the backdrop slots. A write to one of them is duplicated into its partner, which sits at the index with bit 4 flipped, and both entries change in the same clock edge. A greyscale control, when asserted in the cycle of a read request, clears every bit of the returned byte except bits 4 and 5, on either port. Storage keeps the whole byte, and without greyscale a read returns exactly what was written.

Both read ports are registered: the value appears on the clock edge that accepts the request and stays there until the next request on that port. Reads see the memory as it was before a write that lands on the same edge.

Top module: `pal_mem`

## Requirements
- R1: While rst_n is low and after its release, both read outputs are 0x00 and every entry reads back 0x00 until written.
- R2: A host write (cpu_en=1, cpu_we=1, address at or above 0x3F00) stores cpu_wdata at index cpu_addr[4:0]; a host read of that index issued in any later cycle returns the value.
- R3: A host write whose index has bits [1:0] equal to 00 also stores the same byte at the index with bit 4 inverted, on the same clock edge.
- R4: A host write whose index has bits [1:0] not equal to 00 leaves the entry at index XOR 0x10 unchanged.
- R5: When grey_en is 1 in the cycle of a read request, the returned byte equals the stored byte ANDed with 0x30; this applies to both ports.
- R6: A render request (rnd_en=1) reads the entry at index {rnd_pal, rnd_pix} (palette number in bits [4:2], pixel colour in bits [1:0]) and presents it on rnd_data one clock edge later.
- R7: Every host address from 0x3F00 to 0x3FFF selects entry cpu_addr[4:0], so addresses that differ by a multiple of 0x20 reach the same entry.
- R8: A host access with an address below 0x3F00 is ignored: a write changes no entry and a read leaves cpu_rdata unchanged.
- R9: With grey_en at 0 a host read returns all eight stored bits, including bits 7 and 6.
- R10: A read and a write to the same entry on the same clock edge return the value held before that write; a read on the next edge returns the new value. The render port reads while a host write proceeds in the same cycle.
- R11: Each read output holds its value in cycles with no request on its own port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| grey_en | input | 1 | Greyscale masking for reads requested this cycle |
| cpu_en | input | 1 | Host access request |
| cpu_we | input | 1 | Host access is a write when 1, a read when 0 |
| cpu_addr | input | 14 | Host video address |
| cpu_wdata | input | 8 | Host write byte |
| cpu_rdata | output | 8 | Host read byte, registered |
| rnd_en | input | 1 | Render read request |
| rnd_pal | input | 3 | Palette number for the render read |
| rnd_pix | input | 2 | Pixel colour for the render read |
| rnd_data | output | 8 | Render read byte, registered |

## Verification
Every read result is due on the first rising edge after the request is driven, and a write becomes visible to a read driven on the following cycle. The bench drives all inputs just after a falling edge, works out the expected bytes from its own model state before folding in that cycle's write, and compares both outputs at the next falling edge, half a period after the edge that loads them. In cycles with no request it expects the previous byte again, which covers the hold behaviour and the ignored out-of-range accesses.

// File: rtl/pal_mem_pkg.sv
`timescale 1ns/1ps
package pal_mem_pkg;

   // Default geometry of the palette store
   localparam int unsigned PM_DATA_W      = 8;
   localparam int unsigned PM_IDX_W       = 5;
   localparam int unsigned PM_PIX_W       = 2;
   localparam int unsigned PM_ADDR_W      = 14;
   localparam int unsigned PM_REGION_BASE = 'h3F00;
   localparam int unsigned PM_GREY_MASK   = 'h30;

   // Decoded host operation
   typedef enum logic [1:0] {
      PM_OP_IDLE  = 2'd0,
      PM_OP_READ  = 2'd1,
      PM_OP_WRITE = 2'd2
   } pm_op_e;

endpackage

// File: rtl/pal_index_decode.sv
`timescale 1ns/1ps
module pal_index_decode
   import pal_mem_pkg::*;
#(
   parameter int unsigned ADDR_W      = PM_ADDR_W,
   parameter int unsigned IDX_W       = PM_IDX_W,
   parameter int unsigned PIX_W       = PM_PIX_W,
   parameter int unsigned REGION_BASE = PM_REGION_BASE
) (
   input  logic                     cpu_en,
   input  logic                     cpu_we,
   input  logic [ADDR_W-1:0]        cpu_addr,
   input  logic [IDX_W-PIX_W-1:0]   rnd_pal,
   input  logic [PIX_W-1:0]         rnd_pix,
   output pm_op_e                   cpu_op,
   output logic [IDX_W-1:0]         cpu_idx,
   output logic [IDX_W-1:0]         rnd_idx
);

   localparam int unsigned DEPTH = 1 << IDX_W;
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(REGION_BASE);

   if (REGION_BASE % DEPTH != 0) begin : g_bad_base
      $error("REGION_BASE must be aligned to the entry count");
   end
   if (IDX_W > ADDR_W) begin : g_bad_addr
      $error("IDX_W must not exceed ADDR_W");
   end
   if (PIX_W >= IDX_W) begin : g_bad_pix
      $error("PIX_W must leave room for a palette number");
   end

   logic region_hit;

   // Region decode: everything from the base upward aliases the store
   assign region_hit = (cpu_addr >= BASE);
   assign cpu_idx    = cpu_addr[IDX_W-1:0];

   always_comb begin
      cpu_op = PM_OP_IDLE;
      if (cpu_en && region_hit) begin
         cpu_op = cpu_we ? PM_OP_WRITE : PM_OP_READ;
      end
   end

   // Render index: palette number above the pixel colour
   assign rnd_idx = {rnd_pal, rnd_pix};

endmodule

// File: rtl/pal_store.sv
`timescale 1ns/1ps
module pal_store #(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned IDX_W        = 5,
   parameter bit          MIRROR_EN    = 1'b1,
   parameter int unsigned MIRROR_LSB_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  ra_idx,
   output logic [DATA_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic [DATA_W-1:0] rb_data
);

   localparam int unsigned DEPTH = 1 << IDX_W;
   localparam logic [IDX_W-1:0] FLIP = IDX_W'(1) << (IDX_W - 1);

   if (MIRROR_LSB_W == 0 || MIRROR_LSB_W >= IDX_W) begin : g_bad_lsb
      $error("MIRROR_LSB_W must lie between 1 and IDX_W-1");
   end
   if (DEPTH > 1024) begin : g_bad_depth
      $error("palette store kept deliberately small");
   end

   logic [DEPTH-1:0][DATA_W-1:0] ent;
   logic [IDX_W-1:0]             partner;
   logic                         mirror_hit;

   assign partner = wr_idx ^ FLIP;

   if (MIRROR_EN) begin : g_mirror
      assign mirror_hit = (wr_idx[MIRROR_LSB_W-1:0] == '0);
   end else begin : g_no_mirror
      assign mirror_hit = 1'b0;
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic              sel;
      logic [DATA_W-1:0] q;

      assign sel = wr_en &&
                   ((wr_idx == IDX_W'(g)) || (mirror_hit && (partner == IDX_W'(g))));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (sel) begin
            q <= wr_data;
         end
      end

      assign ent[g] = q;
   end

   // Two independent combinational read ports
   assign ra_data = ent[ra_idx];
   assign rb_data = ent[rb_idx];

   // R2
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ent[$past(wr_idx)] == $past(wr_data));

   if (MIRROR_EN) begin : g_mirror_chk
      // R3
      backdrop_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_idx[MIRROR_LSB_W-1:0] == '0)
            |=> ent[$past(wr_idx) ^ FLIP] == $past(wr_data));
   end

   // R4
   partner_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx[MIRROR_LSB_W-1:0] != '0)
         |=> ent[$past(wr_idx) ^ FLIP] == $past(ent[wr_idx ^ FLIP]));

   // R8
   idle_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ent));

endmodule

// File: rtl/pal_read_port.sv
`timescale 1ns/1ps
module pal_read_port #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned GREY_MASK = 'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              grey,
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] q
);

   localparam logic [DATA_W-1:0] MASK = DATA_W'(GREY_MASK);

   if (GREY_MASK >= (1 << DATA_W)) begin : g_bad_mask
      $error("GREY_MASK wider than DATA_W");
   end

   logic [DATA_W-1:0] shaped;

   assign shaped = grey ? (raw & MASK) : raw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (req) begin
         q <= shaped;
      end
   end

   // R5
   grey_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && grey) |=> (q & ~MASK) == '0);

   // R11
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> $stable(q));

   // R9
   full_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !grey) |=> q == $past(raw));

endmodule

// File: rtl/pal_mem.sv
`timescale 1ns/1ps
module pal_mem
   import pal_mem_pkg::*;
#(
   parameter int unsigned DATA_W      = PM_DATA_W,
   parameter int unsigned IDX_W       = PM_IDX_W,
   parameter int unsigned PIX_W       = PM_PIX_W,
   parameter int unsigned ADDR_W      = PM_ADDR_W,
   parameter int unsigned REGION_BASE = PM_REGION_BASE,
   parameter int unsigned GREY_MASK   = PM_GREY_MASK,
   parameter bit          MIRROR_EN   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    grey_en,
   input  logic                    cpu_en,
   input  logic                    cpu_we,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic [DATA_W-1:0]       cpu_wdata,
   output logic [DATA_W-1:0]       cpu_rdata,
   input  logic                    rnd_en,
   input  logic [IDX_W-PIX_W-1:0]  rnd_pal,
   input  logic [PIX_W-1:0]        rnd_pix,
   output logic [DATA_W-1:0]       rnd_data
);

   localparam int unsigned MIRROR_LSB_W = PIX_W;

   pm_op_e            cpu_op;
   logic [IDX_W-1:0]  cpu_idx;
   logic [IDX_W-1:0]  rnd_idx;
   logic [DATA_W-1:0] cpu_raw;
   logic [DATA_W-1:0] rnd_raw;
   logic              cpu_wr;
   logic              cpu_rd;

   pal_index_decode #(
      .ADDR_W      (ADDR_W),
      .IDX_W       (IDX_W),
      .PIX_W       (PIX_W),
      .REGION_BASE (REGION_BASE)
   ) decode_i (
      .cpu_en   (cpu_en),
      .cpu_we   (cpu_we),
      .cpu_addr (cpu_addr),
      .rnd_pal  (rnd_pal),
      .rnd_pix  (rnd_pix),
      .cpu_op   (cpu_op),
      .cpu_idx  (cpu_idx),
      .rnd_idx  (rnd_idx)
   );

   assign cpu_wr = (cpu_op == PM_OP_WRITE);
   assign cpu_rd = (cpu_op == PM_OP_READ);

   pal_store #(
      .DATA_W       (DATA_W),
      .IDX_W        (IDX_W),
      .MIRROR_EN    (MIRROR_EN),
      .MIRROR_LSB_W (MIRROR_LSB_W)
   ) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cpu_wr),
      .wr_idx  (cpu_idx),
      .wr_data (cpu_wdata),
      .ra_idx  (cpu_idx),
      .ra_data (cpu_raw),
      .rb_idx  (rnd_idx),
      .rb_data (rnd_raw)
   );

   pal_read_port #(
      .DATA_W    (DATA_W),
      .GREY_MASK (GREY_MASK)
   ) cpu_port_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (cpu_rd),
      .grey  (grey_en),
      .raw   (cpu_raw),
      .q     (cpu_rdata)
   );

   pal_read_port #(
      .DATA_W    (DATA_W),
      .GREY_MASK (GREY_MASK)
   ) rnd_port_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (rnd_en),
      .grey  (grey_en),
      .raw   (rnd_raw),
      .q     (rnd_data)
   );

   // R8
   outside_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_en && !cpu_we && cpu_addr < ADDR_W'(REGION_BASE)) |=> $stable(cpu_rdata));

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (cpu_rdata == '0 && rnd_data == '0));

endmodule

// File: tb/pal_mem_tb.sv
`timescale 1ns/1ps
module pal_mem_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        grey_en = 1'b0;
   logic        cpu_en = 1'b0;
   logic        cpu_we = 1'b0;
   logic [13:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic        rnd_en = 1'b0;
   logic [2:0]  rnd_pal = '0;
   logic [1:0]  rnd_pix = '0;
   logic [7:0]  rnd_data;

   int n_checks = 0;
   int n_fail   = 0;

   logic [7:0] model [32];
   logic [7:0] exp_cpu = 8'h00;
   logic [7:0] exp_rnd = 8'h00;

   always #2.5 clk = ~clk;

   pal_mem dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .grey_en   (grey_en),
      .cpu_en    (cpu_en),
      .cpu_we    (cpu_we),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_rdata (cpu_rdata),
      .rnd_en    (rnd_en),
      .rnd_pal   (rnd_pal),
      .rnd_pix   (rnd_pix),
      .rnd_data  (rnd_data)
   );

   function automatic logic [7:0] shade(input logic [7:0] v, input bit g);
      return g ? (v & 8'h30) : v;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   // One bench cycle: drive after a falling edge, predict, check at the next one
   task automatic step(input string ctag, input string rtag,
                       input bit c_en, input bit c_we, input logic [13:0] a,
                       input logic [7:0] d, input bit r_en, input logic [2:0] p,
                       input logic [1:0] x, input bit g);
      logic [4:0] wi;
      cpu_en = c_en; cpu_we = c_we; cpu_addr = a; cpu_wdata = d;
      rnd_en = r_en; rnd_pal = p; rnd_pix = x; grey_en = g;
      // predictions use the memory before this cycle's write (R10)
      if (c_en && !c_we && a >= 14'h3F00) exp_cpu = shade(model[a[4:0]], g);
      if (r_en) exp_rnd = shade(model[{p, x}], g);
      if (c_en && c_we && a >= 14'h3F00) begin
         wi = a[4:0];
         model[wi] = d;
         if (wi[1:0] == 2'b00) model[wi ^ 5'h10] = d;
      end
      @(negedge clk);
      check(ctag, cpu_rdata, exp_cpu);
      check(rtag, rnd_data, exp_rnd);
   endtask

   task automatic wr(input string tag, input logic [13:0] a, input logic [7:0] d);
      step(tag, tag, 1'b1, 1'b1, a, d, 1'b0, 3'd0, 2'd0, 1'b0);
   endtask

   task automatic rd(input string tag, input logic [13:0] a, input bit g);
      step(tag, tag, 1'b1, 1'b0, a, 8'h00, 1'b0, 3'd0, 2'd0, g);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) model[i] = 8'h00;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: outputs cleared during reset
      check("R1", cpu_rdata, 8'h00);
      check("R1", rnd_data, 8'h00);
      rst_n = 1'b1;
      rd("R1", 14'h3F07, 1'b0);
      step("R1", "R1", 1'b0, 1'b0, 14'h0, 8'h0, 1'b1, 3'd5, 2'd3, 1'b0);

      // R2 / R9: full byte written and read back
      wr("R2", 14'h3F05, 8'hC7);
      rd("R9", 14'h3F05, 1'b0);
      check("R9", cpu_rdata, 8'hC7);

      // R3: backdrop writes reach the partner in both directions
      wr("R3", 14'h3F00, 8'h21);
      rd("R3", 14'h3F10, 1'b0);
      check("R3", cpu_rdata, 8'h21);
      wr("R3", 14'h3F1C, 8'h1A);
      rd("R3", 14'h3F0C, 1'b0);
      check("R3", cpu_rdata, 8'h1A);

      // R4: non-backdrop write leaves partner alone
      wr("R4", 14'h3F06, 8'h33);
      rd("R4", 14'h3F16, 1'b0);
      check("R4", cpu_rdata, 8'h00);

      // R7: aliasing across the window
      rd("R7", 14'h3FE5, 1'b0);
      check("R7", cpu_rdata, 8'hC7);
      wr("R7", 14'h3F25, 8'h0F);
      rd("R7", 14'h3FC5, 1'b0);
      check("R7", cpu_rdata, 8'h0F);

      // R8: below the window nothing happens
      wr("R8", 14'h0005, 8'hFF);
      wr("R8", 14'h3EE5, 8'hEE);
      rd("R8", 14'h3F05, 1'b0);
      check("R8", cpu_rdata, 8'h0F);
      rd("R8", 14'h2005, 1'b0);
      check("R8", cpu_rdata, 8'h0F);

      // R5: greyscale on both ports
      wr("R5", 14'h3F09, 8'hFF);
      rd("R5", 14'h3F09, 1'b1);
      check("R5", cpu_rdata, 8'h30);
      step("R5", "R5", 1'b0, 1'b0, 14'h0, 8'h0, 1'b1, 3'd2, 2'd1, 1'b1);
      check("R5", rnd_data, 8'h30);

      // R6: render index = {palette, pixel}
      step("R6", "R6", 1'b0, 1'b0, 14'h0, 8'h0, 1'b1, 3'd1, 2'd2, 1'b0);
      check("R6", rnd_data, 8'h33);

      // R10: same-edge write and reads see the old value, then the new one
      step("R10", "R10", 1'b1, 1'b1, 14'h3F09, 8'h5A, 1'b1, 3'd2, 2'd1, 1'b0);
      check("R10", rnd_data, 8'hFF);
      step("R10", "R10", 1'b1, 1'b0, 14'h3F09, 8'h0, 1'b1, 3'd2, 2'd1, 1'b0);
      check("R10", rnd_data, 8'h5A);
      check("R10", cpu_rdata, 8'h5A);

      // R11: outputs hold with no requests
      step("R11", "R11", 1'b0, 1'b0, 14'h3F00, 8'h0, 1'b0, 3'd0, 2'd0, 1'b1);
      step("R11", "R11", 1'b1, 1'b1, 14'h3F09, 8'h77, 1'b0, 3'd0, 2'd0, 1'b0);
      check("R11", cpu_rdata, 8'h5A);
      check("R11", rnd_data, 8'h5A);

      // Random traffic mixed across all requirements
      for (int k = 0; k < 2000; k++) begin
         bit          c_en = ($urandom % 4) != 0;
         bit          c_we = $urandom % 2;
         bit          r_en = ($urandom % 3) != 0;
         bit          g    = ($urandom % 5) == 0;
         logic [13:0] a;
         a = ($urandom % 8 == 0) ? 14'($urandom) : (14'h3F00 | 14'($urandom % 256));
         step(g ? "R5" : "R2", g ? "R5" : "R6", c_en, c_we, a, 8'($urandom),
              r_en, 3'($urandom), 2'($urandom), g);
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule